// File: doc/BRIEF.md
# Daisy-Chainable Serial Register Slave

This block is the serial front end of a multichannel converter's register file. A host frames each transfer with an active-low strobe. Inside a frame, the host sends a 24-bit command one bit per serial clock, most significant bit first. When the strobe rises, the block checks that the frame was complete. It then latches the command and either writes a 12-bit value into a small register array or records a read request. The next frame returns the requested value on the serial output. It comes out in the same bit order, with the request's upper twelve bits echoed above the data.

The serial output has a second use, selected by a static chain-enable input: it forwards to the next device the bits that overflow the 24-bit shift register. This lets several devices share one frame of 24 clocks per device. The block samples the serial clock, strobe and data with its own system clock, so all of its internal logic runs in one clock domain. The serial clock may run continuously or arrive in bursts. The design accepts either idle level between frames.

Top module: `chainable_spi_regs`

## Requirements
- R1: A frame opens on a falling edge of `sync_n` and closes on its rising edge. `din` is sampled on each falling edge of `sclk` inside the frame, MSB first, and the last 24 bits sampled are latched when the frame closes.
- R2: A frame that closes after fewer than 24 falling `sclk` edges is discarded. No register changes, and a pending readback stays pending and is sent again in the next frame.
- R3: While `sync_n` is high, `sclk` and `din` activity has no effect on the registers. A free-running clock between frames changes nothing.
- R4: With `chain_en` high and no readback in progress, each rising `sclk` edge drives onto `sdo` the bit that was sampled 24 falling edges earlier in the same frame, and zeros before that. In a 48-clock frame through two chained devices, the first 24 bits land in the far device and the last 24 in the near one.
- R5: The command layout is: bit 22 is the read flag, bits 21:17 the channel, bits 15:14 the register select, and bits 11:0 the data. Bits 23, 16 and 13:12 are ignored. A complete frame with the read flag at 0 that is not all zeros stores the data bits in the entry chosen by channel and select.
- R6: In the frame after a read request, `sdo` carries request bits 23:12 followed by the selected entry's 12 bits, MSB first. The first bit is present from the strobe's falling edge, and the output advances on each rising `sclk` edge after the first falling edge. This works whether `sclk` idles high or low.
- R7: An all-zero command changes no register and serves only to clock out a pending readback.
- R8: A complete frame that is not a read request cancels any pending readback. Outside a readback frame with `chain_en` low, `sdo` is 0.
- R9: Channels at or above `NUM_CH` are ignored on write and read back as zero.
- R10: After reset, all entries are zero, no readback is pending and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock |
| sync_n | input | 1 | Active-low frame strobe |
| din | input | 1 | Serial data in |
| chain_en | input | 1 | Static enable for forwarding overflow bits on `sdo` |
| sdo | output | 1 | Serial data out: readback word or chain forward |

## Verification
The bench builds two instances with `NUM_CH` = 8, while the channel field stays 5 bits wide. Channels 8 to 31 can therefore be addressed, so the ignored-write and zero-readback path of R9 is reached. Aliasing onto low channels is also checked. The near instance has chain forwarding on and the far one has it off. With this setup, 48-clock shared frames, per-device readback through the chain, and a quiet `sdo` on the unchained device are all observable at the ports.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int WORD_W  = 24;
  localparam int DATA_W  = 12;
  localparam int CH_W    = 5;
  localparam int SEL_W   = 2;
  localparam int RD_POS  = 22;
  localparam int CH_LSB  = 17;
  localparam int SEL_LSB = 14;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic              rd;
    logic              nop;
    logic [CH_W-1:0]   ch;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } req_t;

  function automatic req_t decode_word(input word_t w);
    req_t r;
    r.rd   = w[RD_POS];
    r.nop  = (w == '0);
    r.ch   = w[CH_LSB +: CH_W];
    r.sel  = w[SEL_LSB +: SEL_W];
    r.data = w[DATA_W-1:0];
    return r;
  endfunction

  function automatic word_t readback_word(input word_t req, input logic [DATA_W-1:0] d);
    return {req[WORD_W-1:DATA_W], d};
  endfunction
endpackage

// File: rtl/spi_edge_sampler.sv
module spi_edge_sampler #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s_q, d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= RST_VAL;
      d_q <= RST_VAL;
    end else begin
      s_q <= pin;
      d_q <= s_q;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign rise[b] = s_q[b] & ~d_q[b];
    assign fall[b] = ~s_q[b] & d_q[b];
  end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic         frame_end,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         din,
  input  logic         chain_en,
  input  logic         rd_pend,
  input  logic [W-1:0] rd_word,
  output logic [W-1:0] word,
  output logic         word_ok,
  output logic         bad_frame,
  output logic         sdo
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic             din_q, in_frame, rd_act, chain_q;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     in_sr, out_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q    <= 1'b0;
      in_frame <= 1'b0;
      rd_act   <= 1'b0;
      chain_q  <= 1'b0;
      cnt      <= '0;
      in_sr    <= '0;
      out_sr   <= '0;
    end else begin
      din_q <= din;
      if (frame_start) begin
        in_frame <= 1'b1;
        cnt      <= '0;
        in_sr    <= '0;
        chain_q  <= 1'b0;
        rd_act   <= rd_pend;
        out_sr   <= rd_word;
      end else if (in_frame) begin
        if (frame_end) begin
          in_frame <= 1'b0;
          rd_act   <= 1'b0;
        end else begin
          if (sclk_fall) begin
            in_sr <= {in_sr[W-2:0], din_q};
            if (cnt != FULL) cnt <= cnt + 1'b1;
          end
          if (sclk_rise) begin
            chain_q <= in_sr[W-1];
            if (cnt != '0) out_sr <= {out_sr[W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign word      = in_sr;
  assign word_ok   = in_frame & frame_end & (cnt == FULL);
  assign bad_frame = in_frame & frame_end & (cnt != FULL);
  assign sdo       = rd_act ? out_sr[W-1] : (chain_en & chain_q);

  // R1
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !frame_start && sclk_fall) |=> $stable(in_sr));
  // R4
  chain_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !frame_end && sclk_rise && chain_en && !rd_act) |=> (sdo == $past(in_sr[W-1])));
  // R6
  rb_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && rd_pend) |=> (sdo == $past(rd_word[W-1])));
endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store #(
  parameter int NUM_CH = 32,
  parameter int CH_W   = 5,
  parameter int SEL_W  = 2,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ENTRIES = NUM_CH * (1 << SEL_W);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam logic [CH_W:0] CH_LIM = (CH_W + 1)'(NUM_CH);

  logic [DATA_W-1:0] mem [ENTRIES];
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_hit, rd_hit;

  assign wr_hit = ({1'b0, wr_ch} < CH_LIM);
  assign rd_hit = ({1'b0, rd_ch} < CH_LIM);
  assign wr_idx = IDX_W'({wr_ch, wr_sel});
  assign rd_idx = IDX_W'({rd_ch, rd_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
    end else if (wr_en && wr_hit) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = rd_hit ? mem[rd_idx] : '0;
endmodule

// File: rtl/chainable_spi_regs.sv
module chainable_spi_regs
  import spi_chain_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sync_n,
  input  logic din,
  input  logic chain_en,
  output logic sdo
);
  logic [1:0]        rise, fall;
  logic              frame_start, frame_end, sclk_rise, sclk_fall;
  word_t             word, rb_q;
  logic              word_ok, bad_frame, pend_q, wr_en;
  req_t              req;
  logic [DATA_W-1:0] rd_data;

  spi_edge_sampler #(.W(2), .RST_VAL(2'b10)) u_edges (
    .clk(clk), .rst_n(rst_n), .pin({sync_n, sclk}), .rise(rise), .fall(fall)
  );

  assign frame_start = fall[1];
  assign frame_end   = rise[1];
  assign sclk_rise   = rise[0];
  assign sclk_fall   = fall[0];

  spi_frame_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_end(frame_end),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .din(din), .chain_en(chain_en),
    .rd_pend(pend_q), .rd_word(rb_q),
    .word(word), .word_ok(word_ok), .bad_frame(bad_frame), .sdo(sdo)
  );

  assign req   = decode_word(word);
  assign wr_en = word_ok & ~req.rd & ~req.nop;

  spi_reg_store #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_ch(req.ch), .wr_sel(req.sel), .wr_data(req.data),
    .rd_ch(req.ch), .rd_sel(req.sel), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rb_q   <= '0;
    end else if (word_ok) begin
      pend_q <= req.rd;
      if (req.rd) rb_q <= readback_word(word, rd_data);
    end
  end

  // R2
  bad_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_frame |=> $stable(pend_q));
  // R8
  cancel_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && !word[RD_POS]) |=> !pend_q);
  // R7
  nop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && word == '0) |-> !wr_en);
endmodule

// File: tb/chainable_spi_regs_bench.sv
module chainable_spi_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic sync_n = 1'b1;
  logic din = 1'b0;
  logic sdo_a, sdo_b;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [11:0] mdl [8][4];

  always #10 clk = ~clk;

  chainable_spi_regs #(.NUM_CH(8)) u_chainable_spi_regs (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
    .din(din), .chain_en(1'b1), .sdo(sdo_a)
  );

  chainable_spi_regs #(.NUM_CH(8)) u_chainable_spi_regs_far (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
    .din(sdo_a), .chain_en(1'b0), .sdo(sdo_b)
  );

  function automatic logic [23:0] mk_word(input bit rd, input logic [4:0] ch,
      input logic [1:0] sel, input logic [11:0] d, input logic [3:0] sp);
    return {sp[3], rd, ch, sp[2], sel, sp[1:0], d};
  endfunction

  function automatic logic [23:0] exp_rb(input logic [23:0] rq, input logic [11:0] d);
    return {rq[23:12], d};
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [47:0] bits, input int n, input bit idle_high,
      output logic [47:0] cap_a, output logic [47:0] cap_b);
    cap_a = '0;
    cap_b = '0;
    sclk = idle_high;
    repeat (4) @(negedge clk);
    sync_n = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      din = bits[n-1-i];
      if (idle_high) begin
        repeat (4) @(negedge clk);
        cap_a[n-1-i] = sdo_a;
        cap_b[n-1-i] = sdo_b;
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
      end else begin
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        cap_a[n-1-i] = sdo_a;
        cap_b[n-1-i] = sdo_b;
        sclk = 1'b0;
        repeat (4) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr_a(input logic [4:0] ch, input logic [1:0] sel, input logic [11:0] d,
      input logic [3:0] sp);
    logic [47:0] ca, cb;
    logic [23:0] w;
    w = mk_word(1'b0, ch, sel, d, sp);
    run_frame({24'b0, w}, 24, 1'b0, ca, cb);
    if (w != 24'h0 && ch < 5'd8) mdl[ch[2:0]][sel] = d;
  endtask

  task automatic rd_a(input string tag, input logic [4:0] ch, input logic [1:0] sel,
      input bit idle_high);
    logic [47:0] ca, cb;
    logic [23:0] rq;
    logic [11:0] ev;
    rq = mk_word(1'b1, ch, sel, 12'($urandom), 4'($urandom));
    run_frame({24'b0, rq}, 24, idle_high, ca, cb);
    run_frame(48'b0, 24, idle_high, ca, cb);
    ev = (ch < 5'd8) ? mdl[ch[2:0]][sel] : 12'h0;
    check(tag, {24'b0, ca[23:0]}, {24'b0, exp_rb(rq, ev)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [47:0] ca, cb;
    logic [23:0] wa, wb, rq;
    void'($urandom(32'd5150));
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 4; s++) mdl[c][s] = 12'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state of the serial outputs
    check("R10 sdo near after reset", {47'b0, sdo_a}, 48'b0);
    check("R10 sdo far after reset", {47'b0, sdo_b}, 48'b0);

    // R4: 48-clock shared frame, far word first
    wa = mk_word(1'b0, 5'd5, 2'd1, 12'h5A5, 4'h0);
    wb = mk_word(1'b0, 5'd6, 2'd2, 12'h3C3, 4'h0);
    run_frame({wb, wa}, 48, 1'b0, ca, cb);
    check("R4 near forwards far word", ca, {24'b0, wb});
    // R8: unchained device, no readback, output low
    check("R8 far sdo low", cb, 48'b0);
    mdl[5][1] = 12'h5A5;

    // R4 / R6: read far device through the chain
    rq = mk_word(1'b1, 5'd6, 2'd2, 12'hFFF, 4'hA);
    run_frame({rq, 24'b0}, 48, 1'b0, ca, cb);
    run_frame(48'b0, 48, 1'b0, ca, cb);
    check("R4 far device got its word", cb, {exp_rb(rq, 12'h3C3), 24'b0});
    // R4 / R6: read near device in a chained frame
    rq = mk_word(1'b1, 5'd5, 2'd1, 12'h000, 4'h5);
    run_frame({24'b0, rq}, 48, 1'b0, ca, cb);
    run_frame(48'b0, 48, 1'b0, ca, cb);
    check("R4 near device got its word", ca, {exp_rb(rq, 12'h5A5), 24'b0});

    // R10: untouched entry reads zero
    rd_a("R10 entry zero after reset", 5'd7, 2'd3, 1'b0);
    // R6: example request layout, clock idling high
    wr_a(5'd0, 2'd1, 12'h9E1, 4'h0);
    run_frame({24'b0, 24'h404ABC}, 24, 1'b1, ca, cb);
    run_frame(48'b0, 24, 1'b1, ca, cb);
    check("R6 idle-high readback", {24'b0, ca[23:0]}, {24'b0, 24'h4049E1});

    // R5: random writes and reads against the model, both idle levels
    for (int k = 0; k < 40; k++) begin
      wr_a(5'($urandom_range(0, 7)), 2'($urandom), 12'($urandom), 4'($urandom));
      if (k % 3 == 0)
        rd_a("R5 random readback", 5'($urandom_range(0, 7)), 2'($urandom), bit'($urandom));
    end
    for (int c = 0; c < 8; c++)
      rd_a("R5 sweep readback", 5'(c), 2'(c), 1'b0);

    // R7: all-zero command leaves the registers alone
    wr_a(5'd2, 2'd3, 12'h7D2, 4'h0);
    run_frame(48'b0, 24, 1'b0, ca, cb);
    rd_a("R7 nop keeps entry", 5'd2, 2'd3, 1'b0);
    wr_a(5'd0, 2'd0, 12'h111, 4'h0);
    run_frame(48'b0, 24, 1'b0, ca, cb);
    rd_a("R7 nop keeps entry zero addr", 5'd0, 2'd0, 1'b0);

    // R2: short frame changes nothing
    wr_a(5'd3, 2'd2, 12'hABC, 4'h0);
    wa = mk_word(1'b0, 5'd3, 2'd2, 12'h123, 4'h0);
    run_frame({28'b0, wa[23:4]}, 20, 1'b0, ca, cb);
    rd_a("R2 short frame discarded", 5'd3, 2'd2, 1'b0);
    // R2: short frame keeps a pending readback
    rq = mk_word(1'b1, 5'd3, 2'd2, 12'h0, 4'h3);
    run_frame({24'b0, rq}, 24, 1'b0, ca, cb);
    run_frame(48'b0, 20, 1'b0, ca, cb);
    run_frame(48'b0, 24, 1'b0, ca, cb);
    check("R2 readback still pending", {24'b0, ca[23:0]}, {24'b0, exp_rb(rq, 12'hABC)});

    // R3: free-running clock while strobe is high
    wr_a(5'd4, 2'd0, 12'h0F0, 4'h0);
    for (int t = 0; t < 20; t++) begin
      din = 1'($urandom);
      sclk = ~sclk;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0;
    rd_a("R3 activity outside frame ignored", 5'd4, 2'd0, 1'b0);

    // R8: non-read frame cancels pending readback
    rq = mk_word(1'b1, 5'd4, 2'd0, 12'h0, 4'h0);
    run_frame({24'b0, rq}, 24, 1'b0, ca, cb);
    wr_a(5'd6, 2'd1, 12'h246, 4'h0);
    run_frame(48'b0, 24, 1'b0, ca, cb);
    check("R8 readback cancelled", {24'b0, ca[23:0]}, 48'b0);
    rd_a("R8 write during cancel stored", 5'd6, 2'd1, 1'b0);

    // R9: channels beyond NUM_CH
    wr_a(5'd1, 2'd2, 12'h321, 4'h0);
    wr_a(5'd9, 2'd2, 12'hEEE, 4'h0);
    rd_a("R9 out-of-range reads zero", 5'd9, 2'd2, 1'b0);
    rd_a("R9 alias channel untouched", 5'd1, 2'd2, 1'b0);
    rd_a("R9 top channel reads zero", 5'd31, 2'd3, 1'b1);

    // R1: MSB-first latch, full-word patterns
    wr_a(5'd7, 2'd1, 12'h800, 4'hF);
    rd_a("R1 msb data bit", 5'd7, 2'd1, 1'b0);
    wr_a(5'd7, 2'd2, 12'h001, 4'hF);
    rd_a("R1 lsb data bit", 5'd7, 2'd2, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule